// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous, fully pipelined static memory with a small, parameterised depth. A new read or write can be issued on every clock, in any mix, and the shared data bus never needs an idle cycle between a read and a write. Read data comes back through an output register. Write data arrives on the bus later than its address, so the write address and byte enables travel down a short pipeline to meet it. A read that targets a location whose write has not yet reached the array is served from the bus value of that write.

A command is a load (a new external address) or an advance (the next beat of a four-beat burst, of the same type as the load that opened it). The burst visits the four locations that share the upper address bits. It goes through them in wrapping linear order or in interleaved order, as the order input selects. Three chip selects gate each load, and a clock enable freezes the whole block. The data bus carries one parity bit next to each data byte, and each byte lane has its own active-low write select.

Top module: `ztb_sram`

## Requirements
- R1: A read command accepted at active edge k drives the stored word on `dq` after active edge k+1. The word stays there until active edge k+2, provided `oe_n` is low.
- R2: For a write command accepted at active edge k, the memory takes its data from `dq` at active edge k+2.
- R3: Byte lane i is `dq[9*i+8:9*i]`: data byte and parity bit together. A write changes lane i only when `bw_n[i]` was low in the cycle that issued that command. The other lanes keep their old contents.
- R4: Reads and writes may alternate on consecutive active cycles with no idle cycle, and every read returns the latest data written to its address.
- R5: A read issued one cycle after a write to the same address returns the merged bytes of that write.
- R6: With `mode` low, beat n of a burst (n = 0..3) uses address bits [1:0] equal to (start + n) mod 4. The upper bits stay fixed.
- R7: With `mode` high, beat n uses address bits [1:0] equal to start XOR n. The upper bits stay fixed.
- R8: An advance (`adv_ld` high) keeps the read or write type of the burst's load. `bw_n` is sampled again on each write beat.
- R9: A load is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A deselected load, and any advance after it, performs no access, does not write the array, and leaves `dq` undriven.
- R10: While `cen_n` is high, no command is taken, no write commits, and the output register and bus drive hold their values.
- R11: `dq` is high impedance during the data phase of a write, in cycles with no read data, and whenever `oe_n` is high.
- R12: After reset, no operation is pending and `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears pending operations |
| cen_n | input | 1 | Clock enable, active low |
| addr | input | AW | Word address; bits [1:0] seed the burst |
| adv_ld | input | 1 | Low: load a new address; high: advance the burst |
| we_n | input | 1 | Write enable on a load, active low |
| bw_n | input | NB | Per-lane write selects, active low |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | NB*9 | Data bus, one 9-bit lane per byte with its parity bit |

## Verification
Latency is counted only in active edges, meaning edges with `cen_n` low. A read's word is due on the bus one active edge after its command. A write's data must be present at the second active edge after its command. The bench mirrors this with a two-stage model of outstanding commands that shifts only on active edges. It compares the bus against the reference array in the phase after each edge, once the data written at that edge has been merged in. When a stall holds the pipeline, the bench keeps the expected value and the driven write data unchanged, so each check falls in the cycle where the result is due.

// File: rtl/ztb_sram.sv
module ztb_sram #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen_n,
  input  logic [AW-1:0] addr,
  input  logic          adv_ld,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          mode,
  input  logic          oe_n,
  inout  wire  [NB*9-1:0] dq
);
  localparam int W     = NB * 9;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic          run, wr_burst;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic          v1, w1, v2, w2, drv;
  logic [AW-1:0] a1, a2;
  logic [NB-1:0] be1, be2;
  logic [W-1:0]  dout, fwd;

  wire go   = ~cen_n;
  wire load = ~adv_ld;
  wire sel  = ~ce1_n & ce2 & ~ce3_n;
  wire [1:0] nxt = cnt + 2'd1;
  wire [1:0] low = mode ? (base[1:0] ^ nxt) : (base[1:0] + nxt);
  wire [AW-1:0] cur_a = load ? addr : {base[AW-1:2], low};
  wire cur_v = load ? sel : run;
  wire cur_w = load ? ~we_n : wr_burst;
  wire hit   = v2 & w2 & (a2 == a1);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign fwd[9*i +: 9] = (hit & be2[i]) ? dq[9*i +: 9] : mem[a1][9*i +: 9];
    always_ff @(posedge clk)
      if (rst_n && go && v2 && w2 && be2[i]) mem[a2][9*i +: 9] <= dq[9*i +: 9];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      v1  <= 1'b0;
      v2  <= 1'b0;
      drv <= 1'b0;
    end else if (go) begin
      if (load) begin
        run      <= sel;
        base     <= addr;
        cnt      <= 2'd0;
        wr_burst <= ~we_n;
      end else if (run) begin
        cnt <= nxt;
      end
      v1  <= cur_v;
      w1  <= cur_w;
      a1  <= cur_a;
      be1 <= ~bw_n;
      v2  <= v1;
      w2  <= w1;
      a2  <= a1;
      be2 <= be1;
      drv <= v1 & ~w1;
      if (v1 & ~w1) dout <= fwd;
    end
  end

  assign dq = (drv & ~oe_n) ? dout : {W{1'bz}};
endmodule

// File: rtl/ztb_sram_chk.sv
module ztb_sram_chk #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cen_n,
  input logic          adv_ld,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          v1,
  input logic          w1,
  input logic          v2,
  input logic          w2,
  input logic          drv,
  input logic [NB*9-1:0] dout
);
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && cen_n) |=> ($stable(dout) && $stable(drv) && $stable(v1) && $stable(v2)));

  a_r9_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !cen_n && !adv_ld && !(!ce1_n && ce2 && !ce3_n)) |=> !v1);

  a_r8_advance_type: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !cen_n && adv_ld && v1) |=> (v1 && (w1 == $past(w1))));

  a_r11_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && w2) |-> !drv);

  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !cen_n && v1 && !w1) |=> drv);
endmodule

bind ztb_sram ztb_sram_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld(adv_ld),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .v1(v1), .w1(w1), .v2(v2), .w2(w2), .drv(drv), .dout(dout)
);

// File: tb/sim_ztb_sram.sv
`timescale 1ns/1ps
module sim_ztb_sram;
  localparam int AW = 6, NB = 4, W = NB * 9, DEPTH = 1 << AW;

  typedef struct packed {
    logic v; logic w; logic [AW-1:0] a; logic [NB-1:0] be;
  } op_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cen_n, adv_ld, we_n, ce1_n, ce2, ce3_n, mode, oe_n;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw_n;
  logic [W-1:0]  tb_dq;
  logic          tb_drv;
  wire  [W-1:0]  dq;
  assign dq = tb_drv ? tb_dq : {W{1'bz}};

  ztb_sram #(.AW(AW), .NB(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .addr(addr), .adv_ld(adv_ld),
    .we_n(we_n), .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .mode(mode), .oe_n(oe_n), .dq(dq)
  );

  logic [W-1:0]  ref_mem [DEPTH];
  op_t           p1, p2;
  logic          m_run, m_w;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic [W-1:0]  wd;
  logic          cur_md;
  int            nvec = 0, nfail = 0, cyc = 0;
  string         tag = "R12";

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] n, logic md);
    logic [1:0] lo;
    lo = md ? (b[1:0] ^ n) : (b[1:0] + n);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw, logic [NB-1:0] be);
    logic [W-1:0] r;
    r = old;
    for (int i = 0; i < NB; i++) if (be[i]) r[9*i +: 9] = nw[9*i +: 9];
    return r;
  endfunction

  task automatic check_bus(input logic oe);
    logic [W-1:0] exp;
    if (p2.v && p2.w) return;
    exp = (p2.v && !p2.w && oe) ? ref_mem[p2.a] : {W{1'bz}};
    nvec++;
    if (dq !== exp) begin
      nfail++;
      $display("FAIL %s: dq actual %h expected %h", tag, dq, exp);
    end
  endtask

  task automatic tick(input logic en, input logic ld, input logic wr, input logic cs,
                      input logic [AW-1:0] a, input logic [NB-1:0] be, input logic oe);
    op_t cur;
    @(negedge clk);
    cen_n = !en; adv_ld = !ld; we_n = !wr; bw_n = ~be; addr = a;
    mode = cur_md; oe_n = !oe;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    if (!cs) case ($urandom % 3)
      0: ce1_n = 1'b1;
      1: ce2 = 1'b0;
      default: ce3_n = 1'b1;
    endcase
    tb_drv = p2.v && p2.w;
    tb_dq = wd;
    #1 check_bus(oe);
    @(posedge clk);
    if (en) begin
      if (p2.v && p2.w) ref_mem[p2.a] = merge(ref_mem[p2.a], wd, p2.be);
      cur = '0;
      cur.be = be;
      if (ld) begin
        m_run = cs; m_base = a; m_cnt = 2'd0; m_w = wr;
        cur.v = cs; cur.w = wr; cur.a = a;
      end else if (m_run) begin
        m_cnt = m_cnt + 2'd1;
        cur.v = 1'b1; cur.w = m_w; cur.a = beat_addr(m_base, m_cnt, cur_md);
      end
      p2 = p1; p1 = cur;
      wd = {$urandom, $urandom};
    end
  endtask

  task automatic ld_op(input logic [AW-1:0] a, input logic wr, input logic [NB-1:0] be);
    tick(1'b1, 1'b1, wr, 1'b1, a, be, 1'b1);
  endtask
  task automatic adv(input logic [NB-1:0] be);
    tick(1'b1, 1'b0, 1'b0, 1'b1, '0, be, 1'b1);
  endtask
  task automatic desel(input logic wr);
    tick(1'b1, 1'b1, wr, 1'b0, AW'(9), '1, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL R4: watchdog actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    rst_n = 1'b0; cen_n = 1'b1; adv_ld = 1'b0; we_n = 1'b1; bw_n = '1; addr = '0;
    ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; mode = 1'b0; oe_n = 1'b0;
    tb_drv = 1'b0; tb_dq = '0; cur_md = 1'b0;
    p1 = '0; p2 = '0; m_run = 1'b0; m_w = 1'b0; m_base = '0; m_cnt = '0; wd = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    tag = "R12";
    nvec++;
    if (dq !== {W{1'bz}}) begin
      nfail++;
      $display("FAIL R12: dq actual %h expected %h", dq, {W{1'bz}});
    end
    desel(1'b0);

    tag = "R2";
    for (int i = 0; i < DEPTH; i++) ld_op(AW'(i), 1'b1, '1);
    tag = "R1";
    for (int i = 0; i < DEPTH; i++) ld_op(AW'(i), 1'b0, '0);

    tag = "R3";
    ld_op(5, 1'b1, 4'b1111); ld_op(5, 1'b1, 4'b0101); desel(1'b0); desel(1'b0);
    ld_op(5, 1'b0, '0); desel(1'b0); desel(1'b0);

    tag = "R5";
    ld_op(7, 1'b1, 4'b0110); ld_op(7, 1'b0, '0); ld_op(7, 1'b1, 4'b1001);
    ld_op(7, 1'b0, '0); desel(1'b0); desel(1'b0);

    tag = "R6";
    cur_md = 1'b0;
    ld_op(6, 1'b0, '0); adv('0); adv('0); adv('0); desel(1'b0); desel(1'b0);
    tag = "R7";
    cur_md = 1'b1;
    ld_op(6, 1'b0, '0); adv('0); adv('0); adv('0); desel(1'b0); desel(1'b0);

    tag = "R8";
    cur_md = 1'b0;
    ld_op(8, 1'b1, 4'b1111); adv(4'b0011); adv(4'b1000); adv(4'b0000);
    ld_op(8, 1'b0, '0); adv('0); adv('0); adv('0); desel(1'b0); desel(1'b0);

    tag = "R9";
    desel(1'b1); adv('1); adv('1); desel(1'b1); desel(1'b0); desel(1'b0);
    ld_op(9, 1'b0, '0); desel(1'b0); desel(1'b0);

    tag = "R10";
    ld_op(10, 1'b1, '1); ld_op(11, 1'b0, '0);
    tick(1'b0, 1'b1, 1'b0, 1'b1, 3, '0, 1'b1);
    tick(1'b0, 1'b1, 1'b0, 1'b1, 3, '0, 1'b1);
    ld_op(10, 1'b0, '0);
    tick(1'b0, 1'b1, 1'b1, 1'b1, 4, '1, 1'b1);
    desel(1'b0); desel(1'b0);

    tag = "R11";
    ld_op(12, 1'b0, '0);
    tick(1'b1, 1'b1, 1'b0, 1'b1, 13, '0, 1'b0);
    tick(1'b1, 1'b1, 1'b1, 1'b1, 14, '1, 1'b1);
    desel(1'b0); desel(1'b0);

    tag = "R4";
    for (int i = 0; i < 6000; i++) begin
      logic en, oe;
      int k;
      cur_md = (i >= 3000);
      en = ($urandom % 10) != 0;
      oe = ($urandom % 20) != 0;
      k = $urandom % 8;
      if (k < 2)
        tick(en, 1'b0, 1'b0, 1'b1, '0, NB'($urandom), oe);
      else if (k == 2)
        tick(en, 1'b1, 1'($urandom), 1'b0, AW'($urandom), NB'($urandom), oe);
      else
        tick(en, 1'b1, 1'($urandom), 1'b1, AW'($urandom % 16), NB'($urandom), oe);
    end
    desel(1'b0); desel(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule